// File: doc/BRIEF.md
# March C Memory Self-Test Controller

This block tests a single-port synchronous RAM with the six-element March C algorithm and reports whether the memory is sound. Before a run, software places a lower and an upper word address on the window inputs. A one-cycle start pulse then latches that window and hands the RAM port to the controller. The controller sweeps every cell of the window six times, alternating ascending and descending passes, and checks each word it reads against the background it expects. It finishes the sequence or stops at the first failure.

Every word inside the window is overwritten, so only the window's contents are lost. Setting a narrow window lets a running system test one slice of memory at a time, provided it saves that slice first. The RAM is assumed to return read data one clock after a read is requested. Each read is therefore compared in the following cycle, and that cycle also carries the element's write to the same cell.

Results are a level `done_o`, a sticky `fail_o`, and the address and element number of the first miscompare. These outputs hold until the next accepted start.

Top module: `march_c_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o`, `fail_o`, `mem_we_o` and `mem_re_o` are all 0.
- R2: Element 1 writes the all-zero word to every cell from the lower to the upper window address, one cell per cycle, starting in the cycle after the start pulse.
- R3: Elements 2 and 3 run in ascending order. For each cell, a read is requested in one cycle and a write to the same address follows in the next cycle. Element 2 expects all-zeros and writes all-ones. Element 3 expects all-ones and writes all-zeros.
- R4: Elements 4 and 5 do the same as elements 2 and 3 respectively, but run from the upper to the lower address.
- R5: Element 6 reads every cell in ascending order and expects all-zeros, using a read cycle followed by an idle cycle. A clean run keeps `busy_o` high for exactly 11·N cycles, where N = hi − lo + 1. It then raises `done_o` with `fail_o` low, and `done_o` stays high until the next accepted start.
- R6: While busy, the RAM address never leaves the latched window [lo, hi], and the element number advances only by one.
- R7: Read data is sampled and compared one cycle after the read request.
- R8: On the first miscompare, the controller sets `fail_o`, captures the failing address and the element number (1 to 6, in execution order), and issues no write in that cycle. In the next cycle, `busy_o` is low and `done_o` is high. A later start clears `fail_o`.
- R9: A start pulse while `busy_o` is high is ignored. The window stays as latched and the run length is unchanged.
- R10: A start with lo > hi raises `done_o` in the next cycle with `fail_o` low, never raises `busy_o`, and performs no RAM access.
- R11: `mem_we_o` and `mem_re_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start request |
| addr_lo_i | input | ADDR_W | Lower window address, latched at start |
| addr_hi_i | input | ADDR_W | Upper window address, latched at start |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_re_o | output | 1 | RAM read enable |
| mem_rdata_i | input | DATA_W | RAM read data, valid one cycle after the read request |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished; held until the next start |
| fail_o | output | 1 | A miscompare was found |
| fail_addr_o | output | ADDR_W | Address of the first miscompare |
| fail_elem_o | output | 3 | Element (1 to 6) of the first miscompare |

## Verification
A wrong element counter or direction bit shows up at once on the RAM port. It appears as an address out of order, a write with the wrong background, or a missing read, and the bench catches these by comparing a complete cycle-by-cycle trace of a two-cell window. Broken window bounds or termination show up as accesses outside the window, or as a busy time different from 11·N cycles. A faulty compare path shows up only when a defect is present. For that reason, stuck-at and coupling faults are injected into the bench RAM. Each fault is placed so that a known element first trips at a known cell, and a one-cycle timing slip moves the report to another element or address.

// File: rtl/march_c_pkg.sv
package march_c_pkg;
  typedef enum logic [2:0] {
    EL_W0      = 3'd1,
    EL_UP_R0W1 = 3'd2,
    EL_UP_R1W0 = 3'd3,
    EL_DN_R0W1 = 3'd4,
    EL_DN_R1W0 = 3'd5,
    EL_R0      = 3'd6
  } elem_e;

  function automatic logic elem_up(elem_e e);
    return !(e == EL_DN_R0W1 || e == EL_DN_R1W0);
  endfunction

  function automatic logic elem_exp_ones(elem_e e);
    return (e == EL_UP_R1W0 || e == EL_DN_R1W0);
  endfunction

  function automatic logic elem_wr_ones(elem_e e);
    return (e == EL_UP_R0W1 || e == EL_DN_R0W1);
  endfunction
endpackage

// File: rtl/march_c_addr.sv
module march_c_addr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] ld_val_i,
  input  logic              step_i,
  input  logic              up_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] One = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= ld_val_i;
    else if (step_i) addr_q <= up_i ? addr_q + One : addr_q - One;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == end_i);

  a_r3_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && up_i |=> addr_o == $past(addr_o) + One);
  a_r4_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !up_i |=> addr_o == $past(addr_o) - One);
endmodule

// File: rtl/march_c_cmp.sv
module march_c_cmp
  import march_c_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic              exp_ones_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  elem_e             elem_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              chk_v_o,
  output logic              mismatch_o,
  output logic [ADDR_W-1:0] addr_o,
  output elem_e             elem_o
);
  logic              chk_v_q;
  logic [DATA_W-1:0] exp_q;
  logic [ADDR_W-1:0] addr_q;
  elem_e             elem_q;

  // expected word and tag travel with the read, compared when data returns
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_v_q <= 1'b0;
      exp_q   <= '0;
      addr_q  <= '0;
      elem_q  <= EL_W0;
    end else begin
      chk_v_q <= re_i;
      if (re_i) begin
        exp_q  <= {DATA_W{exp_ones_i}};
        addr_q <= addr_i;
        elem_q <= elem_i;
      end
    end
  end

  assign chk_v_o    = chk_v_q;
  assign mismatch_o = chk_v_q && (rdata_i != exp_q);
  assign addr_o     = addr_q;
  assign elem_o     = elem_q;

  a_r7_check_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> chk_v_o && addr_o == $past(addr_i));
  a_r7_no_check_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> !chk_v_o);
endmodule

// File: rtl/march_c_ctrl.sv
module march_c_ctrl
  import march_c_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_lo_i,
  input  logic [ADDR_W-1:0] addr_hi_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [2:0]        fail_elem_o
);
  logic              run_q, phase_q, done_q, fail_q;
  elem_e             elem_q, elem_nx;
  logic [ADDR_W-1:0] lo_q, hi_q, fail_addr_q;
  elem_e             fail_elem_q;

  logic              accept, empty, cell_done, last, mismatch, chk_v;
  logic              a_load, a_step, a_up, ld_up;
  logic [ADDR_W-1:0] a_ldval, a_end, addr, c_addr;
  elem_e             c_elem;

  assign accept  = start_i && !run_q;
  assign empty   = addr_lo_i > addr_hi_i;
  assign elem_nx = elem_e'(elem_q + 3'd1);

  // element 1: one write per cell; others: read phase then write/idle phase
  assign mem_re_o    = run_q && elem_q != EL_W0 && !phase_q;
  assign mem_we_o    = run_q && !mismatch &&
                       (elem_q == EL_W0 || (phase_q && elem_q != EL_R0));
  assign mem_wdata_o = {DATA_W{elem_wr_ones(elem_q)}};
  assign mem_addr_o  = addr;
  assign cell_done   = run_q && !mismatch && (elem_q == EL_W0 || phase_q);

  assign ld_up   = accept ? 1'b1 : elem_up(elem_nx);
  assign a_load  = (accept && !empty) || (cell_done && last && elem_q != EL_R0);
  assign a_step  = cell_done && !last;
  assign a_up    = a_load ? ld_up : elem_up(elem_q);
  assign a_ldval = accept ? addr_lo_i : (ld_up ? lo_q : hi_q);
  assign a_end   = elem_up(elem_q) ? hi_q : lo_q;

  march_c_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (a_load),
    .ld_val_i (a_ldval),
    .step_i   (a_step),
    .up_i     (a_up),
    .end_i    (a_end),
    .addr_o   (addr),
    .last_o   (last)
  );

  march_c_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .re_i       (mem_re_o),
    .exp_ones_i (elem_exp_ones(elem_q)),
    .addr_i     (addr),
    .elem_i     (elem_q),
    .rdata_i    (mem_rdata_i),
    .chk_v_o    (chk_v),
    .mismatch_o (mismatch),
    .addr_o     (c_addr),
    .elem_o     (c_elem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      phase_q     <= 1'b0;
      elem_q      <= EL_W0;
      lo_q        <= '0;
      hi_q        <= '0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
      fail_elem_q <= EL_W0;
    end else if (!run_q) begin
      if (start_i) begin
        done_q  <= empty;
        fail_q  <= 1'b0;
        run_q   <= !empty;
        elem_q  <= EL_W0;
        phase_q <= 1'b0;
        lo_q    <= addr_lo_i;
        hi_q    <= addr_hi_i;
      end
    end else if (mismatch) begin
      fail_q      <= 1'b1;
      fail_addr_q <= c_addr;
      fail_elem_q <= c_elem;
      run_q       <= 1'b0;
      done_q      <= 1'b1;
    end else if (elem_q != EL_W0 && !phase_q) begin
      phase_q <= 1'b1;
    end else begin
      phase_q <= 1'b0;
      if (last) begin
        if (elem_q == EL_R0) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          elem_q <= elem_nx;
        end
      end
    end
  end

  assign busy_o      = run_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;
  assign fail_elem_o = fail_elem_q;

  a_r11_we_re_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  a_r6_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (addr >= lo_q && addr <= hi_q));
  a_r6_elem_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> (!run_q || elem_q == $past(elem_q) ||
               elem_q == elem_e'($past(elem_q) + 3'd1)));
  a_r8_stop_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && mismatch |=> !busy_o && done_o && fail_o);
  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && start_i |=> $stable(lo_q) && $stable(hi_q));
  a_r10_empty_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && start_i && empty |=> done_o && !fail_o && !busy_o);
  a_r5_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  a_r7_miss_needs_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch |-> chk_v && phase_q);
endmodule

// File: tb/march_c_ctrl_bench.sv
`timescale 1ns/1ps
module march_c_ctrl_bench;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NV = 10;

  typedef struct packed {
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;
    logic [1:0]    kind;  // 0 none, 1 bit0 stuck-1, 2 bit0 stuck-0, 3 write-ones to fa sets fb bit0
    logic [AW-1:0] fa;
    logic [AW-1:0] fb;
    logic          xfail;
    logic [AW-1:0] xaddr;
    logic [2:0]    xelem;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{6'd0,  6'd63, 2'd0, 6'd0,  6'd0,  1'b0, 6'd0,  3'd0},
    '{6'd10, 6'd20, 2'd1, 6'd15, 6'd0,  1'b1, 6'd15, 3'd2},
    '{6'd10, 6'd20, 2'd2, 6'd12, 6'd0,  1'b1, 6'd12, 3'd3},
    '{6'd10, 6'd20, 2'd3, 6'd11, 6'd18, 1'b1, 6'd18, 3'd2},
    '{6'd10, 6'd20, 2'd3, 6'd18, 6'd11, 1'b1, 6'd11, 3'd4},
    '{6'd30, 6'd40, 2'd1, 6'd5,  6'd0,  1'b0, 6'd0,  3'd0},
    '{6'd7,  6'd7,  2'd2, 6'd7,  6'd0,  1'b1, 6'd7,  3'd3},
    '{6'd7,  6'd7,  2'd0, 6'd0,  6'd0,  1'b0, 6'd0,  3'd0},
    '{6'd0,  6'd0,  2'd1, 6'd0,  6'd0,  1'b1, 6'd0,  3'd2},
    '{6'd62, 6'd63, 2'd3, 6'd63, 6'd62, 1'b1, 6'd62, 3'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] lo = '0, hi = '0, maddr, faddr;
  logic we, re, busy, done, fail;
  logic [DW-1:0] wdata, rdata = '0;
  logic [2:0] felem;

  always #2 clk = ~clk;

  march_c_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_march_c_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .addr_lo_i(lo), .addr_hi_i(hi),
    .mem_addr_o(maddr), .mem_we_o(we), .mem_wdata_o(wdata), .mem_re_o(re),
    .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .fail_o(fail),
    .fail_addr_o(faddr), .fail_elem_o(felem)
  );

  // RAM model with one-cycle read latency and one injectable fault
  logic [DW-1:0] mem [1<<AW];
  logic [1:0]    f_kind = '0;
  logic [AW-1:0] f_a = '0, f_b = '0, w_lo = '0, w_hi = '0;
  int oow = 0, nacc = 0;

  always @(posedge clk) begin
    logic [DW-1:0] rd;
    if (we) begin
      mem[maddr] <= wdata;
      if (f_kind == 2'd3 && maddr == f_a && wdata == '1) mem[f_b] <= mem[f_b] | 8'h01;
    end
    if (re) begin
      rd = mem[maddr];
      if (f_kind == 2'd1 && maddr == f_a) rd[0] = 1'b1;
      if (f_kind == 2'd2 && maddr == f_a) rd[0] = 1'b0;
      rdata <= rd;
    end
  end

  always @(negedge clk) begin
    if (we || re) begin
      nacc++;
      if (maddr < w_lo || maddr > w_hi) oow++;
    end
  end

  int nchk = 0, nerr = 0, cyc_all = 0;

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      nerr++;
      $display("FAIL watchdog R5 run hung: act %0d cycles exp <150000", cyc_all);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  // trace of the first 32 busy cycles: op 0 idle, 1 read, 2 write
  int tr_op [32];
  int tr_a  [32];
  int tr_d  [32];

  task automatic run(input logic [AW-1:0] l, input logic [AW-1:0] h,
                     input int glitch_at, output int cyc);
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hA5;
    w_lo = l; w_hi = h; oow = 0;
    @(negedge clk); lo = l; hi = h; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (busy) begin
      if (cyc < 32) begin
        tr_op[cyc] = we ? 2 : (re ? 1 : 0);
        tr_a[cyc]  = int'(maddr);
        tr_d[cyc]  = int'(wdata);
      end
      if (cyc == glitch_at) begin lo = 6'd0; hi = 6'd63; start = 1'b1; end
      else start = 1'b0;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  int e_op [32];
  int e_a  [32];
  int e_d  [32];
  int ne;

  task automatic push(input int op, input int a, input int d);
    e_op[ne] = op; e_a[ne] = a; e_d[ne] = d; ne++;
  endtask

  initial begin
    int cyc;
    // R1: reset state
    #1;
    chk(!busy && !done && !fail && !we && !re, "R1 outputs in reset", {busy, done, fail, we, re}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fail && !we && !re, "R1 outputs after reset", {busy, done, fail, we, re}, 0);

    // R2 R3 R4 R5: full trace of a two-cell window [3,4]
    f_kind = 2'd0;
    run(6'd3, 6'd4, -1, cyc);
    ne = 0;
    for (int a = 3; a <= 4; a++) push(2, a, 0);
    for (int a = 3; a <= 4; a++) begin push(1, a, 0); push(2, a, 255); end
    for (int a = 3; a <= 4; a++) begin push(1, a, 0); push(2, a, 0); end
    for (int a = 4; a >= 3; a--) begin push(1, a, 0); push(2, a, 255); end
    for (int a = 4; a >= 3; a--) begin push(1, a, 0); push(2, a, 0); end
    for (int a = 3; a <= 4; a++) begin push(1, a, 0); push(0, 0, 0); end
    chk(cyc == 22, "R5 busy cycles two-cell", cyc, 22);
    for (int k = 0; k < 22; k++) begin
      string tg;
      tg = (k < 2) ? "R2" : (k < 10) ? "R3" : (k < 18) ? "R4" : "R5";
      chk(tr_op[k] == e_op[k], {tg, " trace op"}, tr_op[k], e_op[k]);
      if (e_op[k] != 0) chk(tr_a[k] == e_a[k], {tg, " trace addr"}, tr_a[k], e_a[k]);
      if (e_op[k] == 2) chk(tr_d[k] == e_d[k], {tg, " trace wdata"}, tr_d[k], e_d[k]);
    end
    chk(done && !fail, "R5 clean done", {done, fail}, 2);
    repeat (5) @(negedge clk);
    chk(done && !busy, "R5 done held", {done, busy}, 2);

    // vector table: R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      int n;
      f_kind = VEC[v].kind; f_a = VEC[v].fa; f_b = VEC[v].fb;
      run(VEC[v].lo, VEC[v].hi, -1, cyc);
      n = int'(VEC[v].hi) - int'(VEC[v].lo) + 1;
      chk(oow == 0, "R6 access outside window", oow, 0);
      chk(done && !busy, "R8 done at end", {done, busy}, 2);
      chk(fail == VEC[v].xfail, "R7 R8 fail flag", fail, VEC[v].xfail);
      if (VEC[v].xfail) begin
        chk(faddr == VEC[v].xaddr, "R8 fail addr", faddr, VEC[v].xaddr);
        chk(felem == VEC[v].xelem, "R7 R8 fail element", felem, VEC[v].xelem);
        if (VEC[v].kind == 2'd1)
          chk(mem[VEC[v].xaddr] == '0, "R8 no write on miss", mem[VEC[v].xaddr], 0);
      end else begin
        chk(cyc == 11 * n, "R5 busy cycles", cyc, 11 * n);
      end
    end
    f_kind = 2'd0;

    // R9: start while busy ignored
    run(6'd20, 6'd25, 5, cyc);
    chk(cyc == 66, "R9 run length kept", cyc, 66);
    chk(oow == 0, "R9 window kept", oow, 0);
    chk(done && !fail, "R9 clean finish", {done, fail}, 2);

    // R10: empty range
    w_lo = 6'd9; w_hi = 6'd4; nacc = 0;
    @(negedge clk); lo = 6'd9; hi = 6'd4; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done && !fail && !busy, "R10 immediate done", {busy, done, fail}, 2);
    repeat (4) begin
      @(negedge clk);
      chk(!busy, "R10 never busy", busy, 0);
    end
    chk(nacc == 0, "R10 no access", nacc, 0);

    // R11: exclusivity over a clean run
    begin
      int both = 0;
      for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
      w_lo = 6'd1; w_hi = 6'd6;
      @(negedge clk); lo = 6'd1; hi = 6'd6; start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (busy) begin
        if (we && re) both++;
        @(negedge clk);
      end
      chk(both == 0, "R11 we and re together", both, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule